// File: doc/BRIEF.md
# Local Bus Strobe Timing Sequencer

This block runs the control side of one transfer on a simple local bus. It takes a start pulse, a direction bit, a burst length and a 32-bit timing descriptor. From these it drives the active-low read strobe, the active-low write strobe and an active-low wait indication. The descriptor sets how many wait clocks come before the first data beat and how many come between beats. It can also hold the strobe back for a few clocks inside the first wait period, and it can keep write data driven for a few clocks after the write strobe is released.

When its own wait counter has expired, the block watches an active-low ready input. It pulses a beat output for every data transfer that completes, and it pulses a done output once the transfer and any hold clocks are over. The descriptor is applied as a plain input and is captured when a transfer is accepted. Address decoding and the data path stay with the surrounding logic.

Top module: `lbus_strobe_seq`

## Requirements
- R1: After reset, and whenever idle, `rd_n_o`, `wr_n_o` and `wait_n_o` are high, and `busy_o`, `done_o`, `beat_o` and `wdata_drive_o` are low.
- R2: The initial wait count comes from descriptor bits [4:0] for reads and [14:10] for writes. Starting the cycle after `start_i` is accepted, `wait_n_o` is low for exactly that many cycles. A count of zero makes the first cycle a data cycle.
- R3: The strobe delay comes from bits [27:26] for reads and [29:28] for writes. The strobe of the selected direction asserts once that many initial wait cycles have passed. If the delay is equal to or greater than the wait count, the strobe asserts on the first data cycle.
- R4: Once asserted, the strobe stays low through every data cycle and through the between-beat waits. The between-beat wait count comes from bits [9:5] for reads and [19:15] for writes, and `wait_n_o` is low during those waits.
- R5: `ready_n_i` has no effect while `wait_n_o` is low.
- R6: When descriptor bit 20 is 1, a beat completes in the data cycle in which `ready_n_i` is low, and `beat_o` is high in that same cycle. When bit 20 is 0, each beat completes in its first data cycle, whatever the level of `ready_n_i`.
- R7: A transfer has `beats_i`+1 beats (1 to 16). The strobe is released in the cycle after the final beat.
- R8: For writes, `wdata_drive_o` is high from the cycle after the start until the number of clocks in bits [31:30] has passed after `wr_n_o` is released. For reads, the hold field is ignored and `wdata_drive_o` stays low.
- R9: `done_o` is a one-cycle pulse in the cycle after the final beat, or after the last hold clock. `busy_o` is high from the cycle after the start through the done cycle.
- R10: A `start_i` pulse that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| write_i | input | 1 | Direction: 1 = write, 0 = read |
| beats_i | input | BEAT_W | Beat count minus one |
| desc_i | input | 32 | Timing descriptor |
| ready_n_i | input | 1 | Active-low ready from the target |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| wait_n_o | output | 1 | Low while the internal wait counter runs |
| beat_o | output | 1 | Data beat completed this cycle |
| wdata_drive_o | output | 1 | Write data must be driven |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished (one cycle) |

## Verification
The bench uses the default BEAT_W of 4, so a burst value of 15 drives the beat counter through all sixteen beats and down to its last count. With the fixed 2-bit delay and hold fields, the bench can set a delay of 3. That is larger than a small wait count, so the case where the strobe falls back to the first data cycle is tested. The hold field is also tested at its largest value. During every wait period the ready input is held low, and each transfer puts unused timing values in the other direction's fields. As a result, reading ready too early or decoding the wrong direction would show up at once in the traced outputs.

// File: rtl/lbs_pkg.sv
package lbs_pkg;

    localparam int DESC_W = 32;
    localparam int WAIT_W = 5;
    localparam int DLY_W  = 2;

    // descriptor field positions
    localparam int RD_INIT_LSB = 0;
    localparam int RD_GAP_LSB  = 5;
    localparam int WR_INIT_LSB = 10;
    localparam int WR_GAP_LSB  = 15;
    localparam int RDY_EN_BIT  = 20;
    localparam int RD_DLY_LSB  = 26;
    localparam int WR_DLY_LSB  = 28;
    localparam int WR_HOLD_LSB = 30;

    typedef logic [WAIT_W-1:0] wcount_t;
    typedef logic [DLY_W-1:0]  dly_t;

    typedef struct packed {
        logic    write;
        logic    rdy_en;
        wcount_t init;
        wcount_t gap;
        dly_t    dly;
        dly_t    hold;
    } xfer_cfg_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_WAIT = 3'd1,
        S_DATA = 3'd2,
        S_GAP  = 3'd3,
        S_HOLD = 3'd4,
        S_FIN  = 3'd5
    } seq_state_t;

    // Select the timing fields that belong to the requested direction.
    function automatic xfer_cfg_t decode_cfg(input logic [DESC_W-1:0] d, input logic wr);
        xfer_cfg_t c;
        c.write  = wr;
        c.rdy_en = d[RDY_EN_BIT];
        if (wr) begin
            c.init = d[WR_INIT_LSB +: WAIT_W];
            c.gap  = d[WR_GAP_LSB +: WAIT_W];
            c.dly  = d[WR_DLY_LSB +: DLY_W];
            c.hold = d[WR_HOLD_LSB +: DLY_W];
        end else begin
            c.init = d[RD_INIT_LSB +: WAIT_W];
            c.gap  = d[RD_GAP_LSB +: WAIT_W];
            c.dly  = d[RD_DLY_LSB +: DLY_W];
            c.hold = '0;
        end
        return c;
    endfunction

    function automatic logic is_waiting(input seq_state_t s);
        return (s == S_WAIT) || (s == S_GAP);
    endfunction

endpackage

// File: rtl/lbs_cfg_latch.sv
module lbs_cfg_latch
    import lbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DESC_W-1:0] desc_i,
    input  logic              write_i,
    output xfer_cfg_t         cfg_next_o,
    output xfer_cfg_t         cfg_o
);
    xfer_cfg_t cfg_q;

    assign cfg_next_o = decode_cfg(desc_i, write_i);

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (load_i) cfg_q <= cfg_next_o;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/lbs_down_cnt.sv
module lbs_down_cnt #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    input  logic         dec_i,
    output logic         last_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (load_i)              cnt_q <= val_i;
        else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/lbs_strobe_gen.sv
module lbs_strobe_gen #(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear_i,
    input  logic          adv_i,
    input  logic [DW-1:0] dly_i,
    input  logic          in_wait_i,
    input  logic          in_burst_i,
    output logic          strobe_o
);
    localparam logic [DW-1:0] EL_MAX = {DW{1'b1}};

    // cycles spent in the initial wait period, saturating
    logic [DW-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i)                elapsed_q <= '0;
        else if (adv_i && elapsed_q != EL_MAX) elapsed_q <= elapsed_q + 1'b1;
    end

    assign strobe_o = in_burst_i || (in_wait_i && (elapsed_q >= dly_i));
endmodule

// File: rtl/lbus_strobe_seq.sv
module lbus_strobe_seq
    import lbs_pkg::*;
#(
    parameter int BEAT_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              write_i,
    input  logic [BEAT_W-1:0] beats_i,
    input  logic [DESC_W-1:0] desc_i,
    input  logic              ready_n_i,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              wait_n_o,
    output logic              beat_o,
    output logic              wdata_drive_o,
    output logic              busy_o,
    output logic              done_o
);
    seq_state_t        st_q, st_d;
    xfer_cfg_t         cfg_q, cfg_next;
    logic [BEAT_W-1:0] left_q;
    logic              accept, beat_fire, cnt_load, cnt_last, strobe;
    wcount_t           cnt_val;

    assign accept    = start_i && (st_q == S_IDLE);
    assign beat_fire = (st_q == S_DATA) && (!cfg_q.rdy_en || !ready_n_i);

    lbs_cfg_latch u_cfg (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .desc_i     (desc_i),
        .write_i    (write_i),
        .cfg_next_o (cfg_next),
        .cfg_o      (cfg_q)
    );

    lbs_down_cnt #(.W(WAIT_W)) u_wcnt (
        .clk    (clk),
        .rst    (rst),
        .load_i (cnt_load),
        .val_i  (cnt_val),
        .dec_i  (is_waiting(st_q) || st_q == S_HOLD),
        .last_o (cnt_last)
    );

    lbs_strobe_gen #(.DW(DLY_W)) u_stb (
        .clk        (clk),
        .rst        (rst),
        .clear_i    (accept),
        .adv_i      (st_q == S_WAIT),
        .dly_i      (cfg_q.dly),
        .in_wait_i  (st_q == S_WAIT),
        .in_burst_i (st_q == S_DATA || st_q == S_GAP),
        .strobe_o   (strobe)
    );

    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        case (st_q)
            S_IDLE: if (start_i) begin
                if (cfg_next.init == '0) begin
                    st_d = S_DATA;
                end else begin
                    st_d     = S_WAIT;
                    cnt_load = 1'b1;
                    cnt_val  = cfg_next.init;
                end
            end
            S_WAIT: if (cnt_last) st_d = S_DATA;
            S_DATA: if (beat_fire) begin
                if (left_q == '0) begin
                    if (cfg_q.hold != '0) begin
                        st_d     = S_HOLD;
                        cnt_load = 1'b1;
                        cnt_val  = WAIT_W'(cfg_q.hold);
                    end else begin
                        st_d = S_FIN;
                    end
                end else if (cfg_q.gap != '0) begin
                    st_d     = S_GAP;
                    cnt_load = 1'b1;
                    cnt_val  = cfg_q.gap;
                end
            end
            S_GAP:  if (cnt_last) st_d = S_DATA;
            S_HOLD: if (cnt_last) st_d = S_FIN;
            S_FIN:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            left_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept)                         left_q <= beats_i;
            else if (beat_fire && left_q != '0) left_q <= left_q - 1'b1;
        end
    end

    assign rd_n_o        = !(strobe && !cfg_q.write);
    assign wr_n_o        = !(strobe && cfg_q.write);
    assign wait_n_o      = !is_waiting(st_q);
    assign beat_o        = beat_fire;
    assign wdata_drive_o = cfg_q.write && (st_q != S_IDLE) && (st_q != S_FIN);
    assign busy_o        = (st_q != S_IDLE);
    assign done_o        = (st_q == S_FIN);
endmodule

// File: rtl/lbus_strobe_seq_chk.sv
module lbus_strobe_seq_chk (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic ready_n_i,
    input logic rdy_en_i,
    input logic rd_n_o,
    input logic wr_n_o,
    input logic wait_n_o,
    input logic beat_o,
    input logic busy_o,
    input logic done_o
);
    // R1: the two strobes are never low together
    a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n_o && !wr_n_o));

    // R5: no beat completes while the wait counter runs
    a_r5_no_beat_in_wait: assert property (@(posedge clk) disable iff (rst)
        !wait_n_o |-> !beat_o);

    // R6: with ready enabled, a beat needs ready low
    a_r6_beat_needs_ready: assert property (@(posedge clk) disable iff (rst)
        (beat_o && rdy_en_i) |-> !ready_n_i);

    // R9: done is a single-cycle pulse and leads to idle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    // R10: a start during a busy, non-final cycle does not end the transfer
    a_r10_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && start_i) |=> busy_o);

    // R7: a strobe is only low while busy
    a_r7_strobe_busy: assert property (@(posedge clk) disable iff (rst)
        (!rd_n_o || !wr_n_o) |-> busy_o);
endmodule

bind lbus_strobe_seq lbus_strobe_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .ready_n_i (ready_n_i),
    .rdy_en_i  (cfg_q.rdy_en),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .wait_n_o  (wait_n_o),
    .beat_o    (beat_o),
    .busy_o    (busy_o),
    .done_o    (done_o)
);

// File: tb/lbus_strobe_seq_bench.sv
module lbus_strobe_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic        write_i = 1'b0;
    logic [3:0]  beats_i = '0;
    logic [31:0] desc_i = '0;
    logic        ready_n_i = 1'b1;
    logic rd_n_o, wr_n_o, wait_n_o, beat_o, wdata_drive_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;
    string cur_tag = "";

    // expected outputs for one cycle
    typedef struct packed {
        logic busy;
        logic done;
        logic beat;
        logic drive;
        logic wait_n;
        logic wr_n;
        logic rd_n;
    } obs_t;

    obs_t expq[$];

    always #2 clk = ~clk;

    lbus_strobe_seq u_lbus_strobe_seq (
        .clk(clk), .rst(rst), .start_i(start_i), .write_i(write_i),
        .beats_i(beats_i), .desc_i(desc_i), .ready_n_i(ready_n_i),
        .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .wait_n_o(wait_n_o),
        .beat_o(beat_o), .wdata_drive_o(wdata_drive_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    function automatic obs_t sample();
        obs_t o;
        o = '{busy: busy_o, done: done_o, beat: beat_o, drive: wdata_drive_o,
              wait_n: wait_n_o, wr_n: wr_n_o, rd_n: rd_n_o};
        return o;
    endfunction

    function automatic string blame(obs_t a, obs_t e);
        string s = "";
        if (a.rd_n != e.rd_n || a.wr_n != e.wr_n) s = {s, "R3/R4/R7 strobe "};
        if (a.wait_n != e.wait_n) s = {s, "R2 wait "};
        if (a.beat != e.beat)     s = {s, "R6 beat "};
        if (a.drive != e.drive)   s = {s, "R8 drive "};
        if (a.done != e.done || a.busy != e.busy) s = {s, "R9 done/busy "};
        return s;
    endfunction

    // monitor: compares one expected item per cycle
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (expq.size() > 0) begin
                obs_t e, a;
                e = expq.pop_front();
                a = sample();
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s %s act=%b exp=%b", cur_tag, blame(a, e), a, e);
                end
            end
        end
    end

    function automatic obs_t mk(bit busy, bit done, bit beat, bit drive,
                                bit wait_n, bit stb, bit wr);
        obs_t o;
        o.busy = busy; o.done = done; o.beat = beat; o.drive = drive;
        o.wait_n = wait_n;
        o.rd_n = !(stb && !wr);
        o.wr_n = !(stb && wr);
        return o;
    endfunction

    // driver: builds the expected trace from the requirements and plays ready
    task automatic run_xfer(input bit wr, input int init, input int dly, input int gap,
                            input int hold, input bit ren, input int nb_i, input int lat,
                            input int restart_at, input string tag);
        obs_t tr[$];
        bit   rq[$];
        logic [31:0] d = '0;
        int nb = nb_i + 1;
        int eh = wr ? hold : 0;
        // fields of the unused direction carry other values (R2, R3)
        if (wr) begin
            d[14:10] = 5'(init); d[19:15] = 5'(gap); d[29:28] = 2'(dly);
            d[4:0] = 5'd7; d[9:5] = 5'd9; d[27:26] = 2'd0;
        end else begin
            d[4:0] = 5'(init); d[9:5] = 5'(gap); d[27:26] = 2'(dly);
            d[14:10] = 5'd6; d[19:15] = 5'd8; d[29:28] = 2'd0;
        end
        d[31:30] = 2'(hold);
        d[20] = ren;
        for (int k = 0; k < init; k++) begin
            tr.push_back(mk(1, 0, 0, wr, 0, k >= dly, wr)); rq.push_back(0); // R5
        end
        for (int b = 0; b < nb; b++) begin
            int l = ren ? lat : 0;
            for (int j = 0; j <= l; j++) begin
                tr.push_back(mk(1, 0, j == l, wr, 1, 1, wr));
                rq.push_back(ren ? (j != l) : 1'b1);
            end
            if (b < nb - 1)
                for (int g = 0; g < gap; g++) begin
                    tr.push_back(mk(1, 0, 0, wr, 0, 1, wr)); rq.push_back(0);
                end
        end
        for (int h = 0; h < eh; h++) begin
            tr.push_back(mk(1, 0, 0, 1, 1, 0, wr)); rq.push_back(0);
        end
        tr.push_back(mk(1, 1, 0, 0, 1, 0, wr)); rq.push_back(1);
        tr.push_back(mk(0, 0, 0, 0, 1, 0, wr)); rq.push_back(1);

        @(negedge clk);
        cur_tag = tag;
        desc_i = d; write_i = wr; beats_i = 4'(nb_i); start_i = 1'b1; ready_n_i = 1'b1;
        @(posedge clk);
        #1;
        foreach (tr[i]) expq.push_back(tr[i]);
        foreach (rq[i]) begin
            @(negedge clk);
            start_i = (i == restart_at);
            if (i == restart_at) write_i = ~wr;   // R10
            ready_n_i = rq[i];
        end
        @(negedge clk);
        start_i = 1'b0; ready_n_i = 1'b1;
        wait (expq.size() == 0);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        checks++;
        if (sample() !== mk(0, 0, 0, 0, 1, 0, 0)) begin
            errors++;
            $display("FAIL R1 reset act=%b exp=%b", sample(), mk(0, 0, 0, 0, 1, 0, 0));
        end
        // R2 R3 R4 R7: read, delayed strobe, gaps, ready disabled (R6)
        run_xfer(0, 3, 1, 2, 0, 0, 1, 0, -1, "T1 R2 R3 R4 R6");
        // R3 delay above wait count, R6 ready latency, R8 hold, R5
        run_xfer(1, 2, 3, 1, 2, 1, 2, 2, -1, "T2 R3 R5 R6 R8");
        // R2 zero wait, R10 restart while busy
        run_xfer(0, 0, 2, 0, 0, 1, 0, 1, 1, "T3 R2 R10");
        // R7 sixteen beats, no gap, no hold
        run_xfer(1, 4, 0, 0, 0, 0, 15, 0, -1, "T4 R7");
        // R8 maximum hold, R10 restart mid burst, R4 long gaps
        run_xfer(1, 1, 0, 3, 3, 1, 1, 0, 3, "T5 R4 R8 R10");
        // R8 read ignores hold, R3 delay equal to wait count
        run_xfer(0, 2, 2, 0, 3, 0, 0, 0, -1, "T6 R3 R8");
        // R1 idle after everything
        @(negedge clk);
        #1;
        checks++;
        if (sample() !== mk(0, 0, 0, 0, 1, 0, 0)) begin
            errors++;
            $display("FAIL R1 idle act=%b exp=%b", sample(), mk(0, 0, 0, 0, 1, 0, 0));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule